// File: doc/BRIEF.md
# Run-Length Sample Packetizer

This block compresses a 16-channel logic sample stream into run-length records and frames them into fixed-size packets for a byte-wide output. Each accepted sample either extends the run that is open or closes it and opens a new one. Closed runs pass through a small record buffer to a serializer. The serializer emits each record as three bytes and ends every group of five records with a sequence byte, which gives 16-byte packets.

A capture starts after reset and ends with the sample flagged as final. The serializer then fills the last packet with zero records and adds whole padding packets until the packet total is a multiple of five. Then it raises `done`. The output uses a valid/ready handshake, and the sample input can be throttled through `in_ready`. Three 32-bit counters are visible at the ports: packets emitted, packets completed ahead of the trigger, and bytes emitted.

Compression helps only when inputs change slowly. A state that changes on every sample costs three bytes per sample, which is more than its raw two bytes.

Top module: `rle_packetizer`

## Requirements
- R1: A record is emitted as three bytes: channel state bits 7:0, then state bits 15:8, then the 8-bit repeat count.
- R2: Consecutive accepted samples with the same state merge into one record whose count equals the number of samples. A change of state closes the run. Cycles without an accepted sample do not break a run.
- R3: A run never exceeds 255 samples. A 256th identical sample closes the run at count 255 and starts a new run with count 1.
- R4: A packet is five records followed by one sequence byte, 16 bytes in all. The sequence byte is 0 for the first packet after reset and increments by one per packet, wrapping from 255 to 0.
- R5: After the final sample, the final run is closed. Any unfilled record slots of the last packet are sent as all-zero records (state 0, count 0).
- R6: Whole padding packets (five zero records plus a sequence byte) follow until the total packet count is a multiple of five. `done` is raised only then.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No byte is lost or duplicated under back-pressure.
- R8: `in_ready` falls when the record buffer is full. A sample is taken only in a cycle where both `in_valid` and `in_ready` are high.
- R9: `pkt_count` counts packets whose sequence byte has been transferred. `wr_pos` counts every transferred byte and equals 16 times `pkt_count` once `done` is high.
- R10: `pkt_before_trig` equals the number of records closed before the run that holds the first sample flagged with `in_trig`, divided by five and rounded down. It is 0 when no trigger occurred, and later trigger flags are ignored.
- R11: After the final sample has been taken, `in_ready` stays low and input activity changes nothing until reset.
- R12: After reset, `out_valid` and `done` are low, all counters are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 16 | Channel state of the sample |
| in_last | input | 1 | Sample is the final one of the capture |
| in_trig | input | 1 | Sample is the trigger point |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| done | output | 1 | Capture fully emitted, padding included |
| pkt_count | output | 32 | Packets emitted |
| pkt_before_trig | output | 32 | Packets completed before the trigger run |
| wr_pos | output | 32 | Bytes emitted |

## Verification
The hardest condition to reach is a full record buffer that stalls the input while a run is half built. It needs short runs arriving faster than the serializer can drain them, together with a sink that accepts rarely. One capture uses random run lengths of 1 to 20 samples against a sink that is ready only one cycle in eight, with gaps in the input. The bench confirms that `in_ready` actually dropped and that the byte stream still matches an independent encoding. A capture of more than 1280 alternating samples drives the sequence byte through its wrap. A constant capture of 600 samples forces the 255-count split.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    localparam int STATE_W        = 16;
    localparam int REP_W          = 8;
    localparam int RECS_PER_PKT   = 5;
    localparam int PKTS_PER_CHUNK = 5;
    localparam int REC_BYTES      = 3;
    localparam int PKT_BYTES      = RECS_PER_PKT * REC_BYTES + 1;
    localparam logic [REP_W-1:0] REP_MAX = {REP_W{1'b1}};

    typedef struct packed {
        logic               last;
        logic [STATE_W-1:0] state;
        logic [REP_W-1:0]   count;
    } rec_t;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_DATA  = 2'd1,
        PH_SEQ   = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    function automatic logic [7:0] rec_byte(input rec_t r, input logic [1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = r.state[7:0];
            2'd1:    b = r.state[15:8];
            default: b = r.count;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rlp_run_encoder.sv
module rlp_run_encoder
    import rlp_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [STATE_W-1:0] in_data,
    input  logic               in_last,
    input  logic               in_trig,
    input  logic               fifo_full,
    output logic               in_ready,
    output logic               push,
    output rec_t               push_rec,
    output logic [POS_W-1:0]   trig_pkts
);

    logic               have;
    logic [STATE_W-1:0] cur_state;
    logic [REP_W-1:0]   cur_cnt;
    logic               flush_pend;
    logic [STATE_W-1:0] pend_state;
    logic               closed;
    logic [POS_W-1:0]   rec_cnt;
    logic               trig_seen;
    logic [POS_W-1:0]   trig_recs;
    logic               accept;
    logic               brk;

    assign in_ready  = !fifo_full && !flush_pend && !closed;
    assign accept    = in_valid && in_ready;
    assign brk       = have && ((in_data != cur_state) || (cur_cnt == REP_MAX));
    assign trig_pkts = trig_recs / POS_W'(RECS_PER_PKT);

    always_comb begin
        push     = 1'b0;
        push_rec = '0;
        if (flush_pend) begin
            if (!fifo_full) begin
                push     = 1'b1;
                push_rec = '{last: 1'b1, state: pend_state, count: REP_W'(1)};
            end
        end else if (accept) begin
            if (in_last) begin
                push = 1'b1;
                if (brk)
                    push_rec = '{last: 1'b0, state: cur_state, count: cur_cnt};
                else if (have)
                    push_rec = '{last: 1'b1, state: cur_state, count: cur_cnt + REP_W'(1)};
                else
                    push_rec = '{last: 1'b1, state: in_data, count: REP_W'(1)};
            end else if (brk) begin
                push     = 1'b1;
                push_rec = '{last: 1'b0, state: cur_state, count: cur_cnt};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have       <= 1'b0;
            cur_state  <= '0;
            cur_cnt    <= '0;
            flush_pend <= 1'b0;
            pend_state <= '0;
            closed     <= 1'b0;
            rec_cnt    <= '0;
            trig_seen  <= 1'b0;
            trig_recs  <= '0;
        end else begin
            if (push)
                rec_cnt <= rec_cnt + POS_W'(1);
            if (flush_pend) begin
                if (!fifo_full) begin
                    flush_pend <= 1'b0;
                    closed     <= 1'b1;
                end
            end else if (accept) begin
                if (in_trig && !trig_seen) begin
                    trig_seen <= 1'b1;
                    trig_recs <= rec_cnt + POS_W'(brk);
                end
                if (in_last) begin
                    have <= 1'b0;
                    if (brk) begin
                        flush_pend <= 1'b1;
                        pend_state <= in_data;
                    end else begin
                        closed <= 1'b1;
                    end
                end else if (brk || !have) begin
                    have      <= 1'b1;
                    cur_state <= in_data;
                    cur_cnt   <= REP_W'(1);
                end else begin
                    cur_cnt <= cur_cnt + REP_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rlp_rec_fifo.sv
module rlp_rec_fifo
    import rlp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  rec_t push_rec,
    input  logic pop,
    output rec_t pop_rec,
    output logic empty,
    output logic full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rec_t          mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop_rec = mem[rp];

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wp] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push && !full)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop && !empty)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({push && !full, pop && !empty})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/rlp_pkt_serializer.sv
module rlp_pkt_serializer
    import rlp_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_empty,
    input  rec_t             fifo_rec,
    output logic             pop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             done,
    output logic [POS_W-1:0] pkt_count,
    output logic [POS_W-1:0] wr_pos
);

    localparam int SLOT_W  = $clog2(RECS_PER_PKT);
    localparam int CHUNK_W = $clog2(PKTS_PER_CHUNK);

    phase_t             phase;
    rec_t               cur;
    logic [1:0]         byte_i;
    logic [SLOT_W-1:0]  slot;
    logic [CHUNK_W-1:0] chunk;
    logic [7:0]         seq;
    logic               ending;
    logic               hs;

    assign out_valid = (phase == PH_DATA) || (phase == PH_SEQ);
    assign out_data  = (phase == PH_SEQ) ? seq : rec_byte(cur, byte_i);
    assign hs        = out_valid && out_ready;
    assign pop       = (phase == PH_FETCH) && !ending && !fifo_empty;
    assign done      = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_FETCH;
            cur       <= '0;
            byte_i    <= '0;
            slot      <= '0;
            chunk     <= '0;
            seq       <= '0;
            ending    <= 1'b0;
            pkt_count <= '0;
            wr_pos    <= '0;
        end else begin
            if (hs)
                wr_pos <= wr_pos + POS_W'(1);
            case (phase)
                PH_FETCH: begin
                    if (ending) begin
                        cur   <= '0;
                        phase <= PH_DATA;
                    end else if (!fifo_empty) begin
                        cur   <= fifo_rec;
                        phase <= PH_DATA;
                        if (fifo_rec.last)
                            ending <= 1'b1;
                    end
                end
                PH_DATA: begin
                    if (hs) begin
                        if (byte_i == 2'(REC_BYTES - 1)) begin
                            byte_i <= '0;
                            if (slot == SLOT_W'(RECS_PER_PKT - 1)) begin
                                slot  <= '0;
                                phase <= PH_SEQ;
                            end else begin
                                slot  <= slot + SLOT_W'(1);
                                phase <= PH_FETCH;
                            end
                        end else begin
                            byte_i <= byte_i + 2'd1;
                        end
                    end
                end
                PH_SEQ: begin
                    if (hs) begin
                        seq       <= seq + 8'd1;
                        pkt_count <= pkt_count + POS_W'(1);
                        if (chunk == CHUNK_W'(PKTS_PER_CHUNK - 1))
                            chunk <= '0;
                        else
                            chunk <= chunk + CHUNK_W'(1);
                        if (ending && chunk == CHUNK_W'(PKTS_PER_CHUNK - 1))
                            phase <= PH_DONE;
                        else
                            phase <= PH_FETCH;
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

endmodule

// File: rtl/rle_packetizer.sv
module rle_packetizer
    import rlp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int POS_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_data,
    input  logic             in_last,
    input  logic             in_trig,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             done,
    output logic [POS_W-1:0] pkt_count,
    output logic [POS_W-1:0] pkt_before_trig,
    output logic [POS_W-1:0] wr_pos
);

    logic push;
    rec_t push_rec;
    logic pop;
    rec_t pop_rec;
    logic fifo_empty;
    logic fifo_full;

    rlp_run_encoder #(.POS_W(POS_W)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_trig   (in_trig),
        .fifo_full (fifo_full),
        .in_ready  (in_ready),
        .push      (push),
        .push_rec  (push_rec),
        .trig_pkts (pkt_before_trig)
    );

    rlp_rec_fifo #(.DEPTH(FIFO_DEPTH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_rec (push_rec),
        .pop      (pop),
        .pop_rec  (pop_rec),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    rlp_pkt_serializer #(.POS_W(POS_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_rec   (pop_rec),
        .pop        (pop),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .done       (done),
        .pkt_count  (pkt_count),
        .wr_pos     (wr_pos)
    );

endmodule

// File: rtl/rlp_checker.sv
module rlp_checker
    import rlp_pkg::*;
#(
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             done,
    input logic [POS_W-1:0] pkt_count,
    input logic [POS_W-1:0] wr_pos
);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_chunk_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pkt_count % POS_W'(PKTS_PER_CHUNK)) == '0));

    assert_pos_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_pos == pkt_count * POS_W'(PKT_BYTES)));

    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (wr_pos == $past(wr_pos) + POS_W'(1)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(wr_pos));

    assert_closed_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

endmodule

bind rle_packetizer rlp_checker #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .pkt_count (pkt_count),
    .wr_pos    (wr_pos)
);

// File: tb/sim_rle_packetizer.sv
module sim_rle_packetizer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_trig = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        done;
    logic [31:0] pkt_count;
    logic [31:0] pkt_before_trig;
    logic [31:0] wr_pos;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int ready_mode = 0;
    int gaps = 0;
    int stalls = 0;
    int trig_a = -1;
    int trig_b = -1;
    int exp_pkts, exp_bytes, exp_trig;
    int byte_idx = 0;
    logic [7:0] first_b [3];
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] smp[$];
    logic [7:0]  exp_q[$];

    always #4 clk = ~clk;

    rle_packetizer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_trig(in_trig),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .pkt_count(pkt_count), .pkt_before_trig(pkt_before_trig),
        .wr_pos(wr_pos)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr;
    endfunction

    // sink readiness, changed away from the sampling edge
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: out_ready <= 1'b1;
            1: out_ready <= lfsr[3];
            default: out_ready <= (lfsr[2:0] == 3'd0);
        endcase
        void'(step_lfsr());
    end

    // monitor: compare every transferred byte against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (byte_idx < 3) first_b[byte_idx] = out_data;
            byte_idx++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 extra byte", out_data, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R4 R5 stream byte", out_data, e);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic build_expect();
        logic [23:0] rq[$];
        logic [15:0] cur;
        int cnt = 0;
        bit have = 0;
        int nrec = 0;
        int trig_rec = -1;
        int pkts = 0;
        exp_q.delete();
        for (int i = 0; i < smp.size(); i++) begin
            bit brk;
            brk = have && ((smp[i] != cur) || cnt == 255);
            if (brk) begin
                rq.push_back({cur, 8'(cnt)});
                nrec++;
            end
            if (brk || !have) begin
                cur = smp[i]; cnt = 1; have = 1;
            end else begin
                cnt++;
            end
            if (i == trig_a && trig_rec < 0) trig_rec = nrec;
        end
        rq.push_back({cur, 8'(cnt)});
        for (int k = 0; k < rq.size(); k++) begin
            exp_q.push_back(rq[k][15:8]);
            exp_q.push_back(rq[k][23:16]);
            exp_q.push_back(rq[k][7:0]);
            if (k % 5 == 4) begin
                exp_q.push_back(8'(pkts));
                pkts++;
            end
        end
        if (rq.size() % 5 != 0) begin
            for (int k = rq.size() % 5; k < 5; k++)
                for (int b = 0; b < 3; b++) exp_q.push_back(8'h00);
            exp_q.push_back(8'(pkts));
            pkts++;
        end
        while (pkts % 5 != 0) begin
            for (int b = 0; b < 15; b++) exp_q.push_back(8'h00);
            exp_q.push_back(8'(pkts));
            pkts++;
        end
        exp_pkts  = pkts;
        exp_bytes = exp_q.size();
        exp_trig  = (trig_rec < 0) ? 0 : trig_rec / 5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0; in_last = 1'b0; in_trig = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        byte_idx = 0;
        stalls = 0;
    endtask

    task automatic drive_all();
        int i = 0;
        int c = 0;
        while (i < smp.size()) begin
            bit acc;
            @(negedge clk);
            c++;
            if (gaps != 0 && c % 7 == 0) begin
                in_valid = 1'b0; in_last = 1'b0; in_trig = 1'b0;
                continue;
            end
            in_valid = 1'b1;
            in_data  = smp[i];
            in_last  = (i == smp.size() - 1);
            in_trig  = (i == trig_a) || (i == trig_b);
            acc = in_ready;
            if (!in_ready) stalls++;
            @(posedge clk);
            if (acc) i++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_trig = 1'b0;
    endtask

    task automatic run_capture(input string name);
        do_reset();
        build_expect();
        drive_all();
        while (!done) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, {"R7 all bytes delivered ", name}, exp_q.size(), 0);
        check(pkt_count == exp_pkts, {"R6 packet total ", name}, pkt_count, exp_pkts);
        check(pkt_count % 5 == 0, {"R6 chunk multiple ", name}, pkt_count % 5, 0);
        check(wr_pos == exp_bytes, {"R9 byte position ", name}, wr_pos, exp_bytes);
        check(pkt_before_trig == exp_trig, {"R10 trigger packets ", name}, pkt_before_trig, exp_trig);
    endtask

    initial begin
        // R12: reset state
        do_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
        check(done == 1'b0, "R12 done", done, 0);
        check(pkt_count == 0 && wr_pos == 0 && pkt_before_trig == 0, "R12 counters",
              pkt_count + wr_pos + pkt_before_trig, 0);
        check(in_ready == 1'b1, "R12 in_ready", in_ready, 1);

        // single sample: byte order, zero padding, padding packets
        smp.delete(); smp.push_back(16'hA55A);
        trig_a = -1; trig_b = -1; ready_mode = 0; gaps = 0;
        run_capture("single");
        check(first_b[0] == 8'h5A, "R1 state low byte", first_b[0], 8'h5A);
        check(first_b[1] == 8'hA5, "R1 state high byte", first_b[1], 8'hA5);
        check(first_b[2] == 8'h01, "R1 count byte", first_b[2], 1);
        check(pkt_count == 5, "R5 R6 padded to five packets", pkt_count, 5);

        // constant input: 255 split, trigger inside second run
        smp.delete();
        for (int i = 0; i < 600; i++) smp.push_back(16'h1234);
        trig_a = 300; trig_b = -1; ready_mode = 1; gaps = 1;
        run_capture("constant R3");
        check(first_b[2] == 8'hFF, "R3 first run count", first_b[2], 255);

        // alternating input: sequence wrap, first trigger only, R2 state changes
        smp.delete();
        for (int i = 0; i < 1290; i++) smp.push_back((i % 2) ? 16'hFF00 : 16'h00FF);
        trig_a = 17; trig_b = 900; ready_mode = 0; gaps = 0;
        run_capture("alternating R2 R4");
        check(pkt_before_trig == 3, "R10 first trigger wins", pkt_before_trig, 3);

        // random runs, rare sink readiness: buffer fills
        smp.delete();
        while (smp.size() < 300) begin
            int len;
            logic [15:0] v;
            v = step_lfsr();
            len = 1 + (step_lfsr() % 20);
            for (int k = 0; k < len; k++) smp.push_back(v);
        end
        trig_a = -1; trig_b = -1; ready_mode = 2; gaps = 1;
        run_capture("random R2");
        check(stalls > 0, "R8 input throttled", stalls, 1);

        // R11: input after the final sample is ignored
        begin
            int pc;
            int wp;
            pc = pkt_count;
            wp = wr_pos;
            check(in_ready == 1'b0, "R11 in_ready low", in_ready, 0);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                in_valid = 1'b1; in_last = 1'b1; in_trig = 1'b1; in_data = 16'h7777;
            end
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0; in_trig = 1'b0;
            repeat (10) @(negedge clk);
            check(out_valid == 1'b0, "R11 no new output", out_valid, 0);
            check(pkt_count == pc && wr_pos == wp, "R11 counters frozen", wr_pos, wp);
            check(pkt_before_trig == 0, "R11 late trigger ignored", pkt_before_trig, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule